// File: doc/BRIEF.md
# Run-time programmable logic array core

This core evaluates a set of Boolean outputs from a set of inputs through three stages. A programmable AND plane forms product terms. A programmable OR plane sums any subset of those terms into each output, so one term can feed several outputs at once. A per-output XOR stage then either passes each sum-of-products through or inverts it. Evaluation is purely combinational from the active configuration.

Software or a sequencer loads a configuration through a single write port. Each write carries a target plane, an index and a data word, and lands in a shadow copy. A one-cycle commit pulse copies the whole shadow into the active configuration in one step, so the outputs never reflect a half-written function set. Typical use is to load all term rows, all output columns and all polarity bits, then pulse commit.

Top module: `pla_core`

## Requirements
- R1: After reset every connection in both planes is cleared and every polarity bit is 0, so every output reads 0 for every input value.
- R2: Each input-to-term connection is a 2-bit code: 00 leaves the input out of the term, 01 uses the input true, 10 uses its complement; a term is the AND of its used literals. A write with wr_sel_i = 0 loads the row of term wr_idx_i, with input i's code in data bits [2i+1:2i].
- R3: Code 11 on any input of a term forces that term to 0 regardless of the inputs.
- R4: A term with every code at 00 evaluates to 1.
- R5: A write with wr_sel_i = 1 loads the OR column of output wr_idx_i; data bit t set connects term t to that output, and one term may feed any number of outputs.
- R6: An output with no connected terms has a sum-of-products of 0, so it reads its polarity bit.
- R7: A write with wr_sel_i = 2 loads data bit 0 as the polarity of output wr_idx_i; 1 inverts the sum-of-products, 0 passes it.
- R8: Writes affect only the shadow copy; outputs keep the previous function until commit_i is high on a clock edge, after which the whole new configuration is active at once.
- R9: With x_i[2]=A, x_i[1]=B, x_i[0]=C, the terms AB, AC, BC and A'B'C', output 0 complemented over AB+AC+BC and output 1 true over AB+AC+A'B'C', output 0 is 1 exactly for input values 0,1,2,4 and output 1 exactly for 0,5,6,7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_sel_i | input | 2 | Target: 0 term row, 1 output column, 2 polarity, 3 none |
| wr_idx_i | input | IW | Term or output index |
| wr_data_i | input | DW | Write data, max(2*N_IN, N_TERM) bits |
| commit_i | input | 1 | One-cycle pulse that makes the shadow active |
| x_i | input | N_IN | Logic inputs |
| y_o | output | N_OUT | Logic outputs |

## Verification
A corrupted shadow or active bit shows directly as a wrong output on some input value in the same cycle it becomes active, so each configuration is checked by sweeping all input values against an independent model. A commit that leaks early or loads late appears as outputs that change before the commit edge or keep the old function after it, which the bench observes by checking just before and just after each commit. A wrong literal decode appears only for input values that separate true from complement, which the exhaustive sweep covers.

// File: rtl/pla_pkg.sv
package pla_pkg;
  typedef enum logic [1:0] {
    CONN_NONE = 2'b00,
    CONN_TRUE = 2'b01,
    CONN_COMP = 2'b10,
    CONN_ZERO = 2'b11
  } conn_e;

  typedef enum logic [1:0] {
    SEL_AND = 2'd0,
    SEL_OR  = 2'd1,
    SEL_POL = 2'd2,
    SEL_NOP = 2'd3
  } wsel_e;
endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 4,
  parameter int N_OUT  = 2,
  parameter int IW     = 2,
  parameter int DW     = 6
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [1:0]                     wr_sel_i,
  input  logic [IW-1:0]                  wr_idx_i,
  input  logic [DW-1:0]                  wr_data_i,
  input  logic                           commit_i,
  output logic [N_TERM-1:0][2*N_IN-1:0]  and_cfg_o,
  output logic [N_OUT-1:0][N_TERM-1:0]   or_cfg_o,
  output logic [N_OUT-1:0]               pol_o
);
  import pla_pkg::*;

  logic [N_TERM-1:0][2*N_IN-1:0] and_sh;
  logic [N_OUT-1:0][N_TERM-1:0]  or_sh;
  logic [N_OUT-1:0]              pol_sh;
  wsel_e                         sel;

  assign sel = wsel_e'(wr_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      and_sh <= '0;
      or_sh  <= '0;
      pol_sh <= '0;
    end else if (wr_en_i) begin
      unique case (sel)
        SEL_AND: if (32'(wr_idx_i) < N_TERM) and_sh[wr_idx_i] <= wr_data_i[2*N_IN-1:0];
        SEL_OR:  if (32'(wr_idx_i) < N_OUT)  or_sh[wr_idx_i]  <= wr_data_i[N_TERM-1:0];
        SEL_POL: if (32'(wr_idx_i) < N_OUT)  pol_sh[wr_idx_i] <= wr_data_i[0];
        default: ;
      endcase
    end
  end

  // active copy changes only on commit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      and_cfg_o <= '0;
      or_cfg_o  <= '0;
      pol_o     <= '0;
    end else if (commit_i) begin
      and_cfg_o <= and_sh;
      or_cfg_o  <= or_sh;
      pol_o     <= pol_sh;
    end
  end

  AST_ACTIVE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> ($stable(and_cfg_o) && $stable(or_cfg_o) && $stable(pol_o))); // R8
  AST_COMMIT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !wr_en_i) |=> (and_cfg_o == and_sh && or_cfg_o == or_sh && pol_o == pol_sh)); // R8
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_IN-1:0]               x_i,
  input  logic [N_TERM-1:0][2*N_IN-1:0] and_cfg_i,
  output logic [N_TERM-1:0]             term_o
);
  import pla_pkg::*;

  logic [N_TERM-1:0][N_IN-1:0] lit;

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    for (genvar i = 0; i < N_IN; i++) begin : g_in
      always_comb begin
        unique case (conn_e'(and_cfg_i[t][2*i+:2]))
          CONN_NONE: lit[t][i] = 1'b1;
          CONN_TRUE: lit[t][i] = x_i[i];
          CONN_COMP: lit[t][i] = ~x_i[i];
          default:   lit[t][i] = 1'b0;
        endcase
      end
      AST_ZERO_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (and_cfg_i[t][2*i+:2] == 2'b11) |-> !term_o[t]); // R3
    end
    assign term_o[t] = &lit[t];
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_TERM = 4,
  parameter int N_OUT  = 2
) (
  input  logic [N_TERM-1:0]             term_i,
  input  logic [N_OUT-1:0][N_TERM-1:0]  or_cfg_i,
  output logic [N_OUT-1:0]              sop_o
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    assign sop_o[o] = |(term_i & or_cfg_i[o]);
  end
endmodule

// File: rtl/pla_pol_stage.sv
module pla_pol_stage #(
  parameter int N_OUT = 2
) (
  input  logic [N_OUT-1:0] sop_i,
  input  logic [N_OUT-1:0] pol_i,
  output logic [N_OUT-1:0] y_o
);
  assign y_o = sop_i ^ pol_i;
endmodule

// File: rtl/pla_core.sv
module pla_core #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 4,
  parameter int N_OUT  = 2,
  localparam int MXI   = (N_TERM > N_OUT) ? N_TERM : N_OUT,
  localparam int IW    = (MXI > 1) ? $clog2(MXI) : 1,
  localparam int DW    = (2*N_IN > N_TERM) ? 2*N_IN : N_TERM
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [IW-1:0]    wr_idx_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             commit_i,
  input  logic [N_IN-1:0]  x_i,
  output logic [N_OUT-1:0] y_o
);
  logic [N_TERM-1:0][2*N_IN-1:0] and_cfg;
  logic [N_OUT-1:0][N_TERM-1:0]  or_cfg;
  logic [N_OUT-1:0]              pol;
  logic [N_TERM-1:0]             term;
  logic [N_OUT-1:0]              sop;

  pla_cfg_store #(
    .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .IW(IW), .DW(DW)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i), .commit_i(commit_i),
    .and_cfg_o(and_cfg), .or_cfg_o(or_cfg), .pol_o(pol)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .clk_i(clk_i), .rst_ni(rst_ni), .x_i(x_i), .and_cfg_i(and_cfg), .term_o(term)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .term_i(term), .or_cfg_i(or_cfg), .sop_o(sop)
  );

  pla_pol_stage #(.N_OUT(N_OUT)) u_pol (
    .sop_i(sop), .pol_i(pol), .y_o(y_o)
  );

  for (genvar o = 0; o < N_OUT; o++) begin : g_chk
    AST_EMPTY_COL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (or_cfg[o] == '0) |-> (y_o[o] == pol[o])); // R6
  end

  AST_Y_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> (!$stable(x_i) || $stable(y_o))); // R8
endmodule

// File: tb/pla_core_tb.sv
module pla_core_tb;
  localparam int N = 3, P = 4, M = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [1:0] wr_idx = '0;
  logic [5:0] wr_data = '0;
  logic       commit = 1'b0;
  logic [2:0] x = '0;
  logic [1:0] y;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [5:0] sh_and [P], ac_and [P];
  logic [3:0] sh_or [M], ac_or [M];
  logic       sh_pol [M], ac_pol [M];

  always #2 clk = ~clk;

  pla_core u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_idx_i(wr_idx), .wr_data_i(wr_data), .commit_i(commit), .x_i(x), .y_o(y)
  );

  function automatic logic ref_y(int o, logic [2:0] xv);
    logic s = 1'b0;
    for (int t = 0; t < P; t++) begin
      logic tv = 1'b1;
      for (int i = 0; i < N; i++) begin
        case (ac_and[t][2*i+:2])
          2'b01: tv = tv & xv[i];
          2'b10: tv = tv & ~xv[i];
          2'b11: tv = 1'b0;
          default: ;
        endcase
      end
      if (ac_or[o][t]) s = s | tv;
    end
    return s ^ ac_pol[o];
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s x=%0d act=%b exp=%b", req, x, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, int idx, logic [5:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_idx = idx[1:0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (s)
      2'd0: sh_and[idx] = d;
      2'd1: sh_or[idx] = d[3:0];
      2'd2: sh_pol[idx] = d[0];
      default: ;
    endcase
  endtask

  task automatic do_commit();
    @(negedge clk);
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    for (int t = 0; t < P; t++) ac_and[t] = sh_and[t];
    for (int o = 0; o < M; o++) begin ac_or[o] = sh_or[o]; ac_pol[o] = sh_pol[o]; end
  endtask

  // sweep all inputs against the model of the committed configuration
  task automatic sweep(string req);
    for (int v = 0; v < 8; v++) begin
      x = v[2:0];
      #1;
      for (int o = 0; o < M; o++) chk(req, y[o], ref_y(o, x));
    end
  endtask

  task automatic t_reset();
    for (int v = 0; v < 8; v++) begin
      x = v[2:0]; #1;
      chk("R1", y[0], 1'b0);
      chk("R1", y[1], 1'b0);
    end
  endtask

  task automatic t_pair();
    wr(2'd0, 0, 6'b01_01_00); // AB
    wr(2'd0, 1, 6'b01_00_01); // AC
    wr(2'd0, 2, 6'b00_01_01); // BC
    wr(2'd0, 3, 6'b10_10_10); // A'B'C'
    wr(2'd1, 0, 6'b00_0111);
    wr(2'd1, 1, 6'b00_1011);
    wr(2'd2, 0, 6'd1);
    wr(2'd2, 1, 6'd0);
    sweep("R8"); // still reset function before commit
    do_commit();
    for (int v = 0; v < 8; v++) begin
      x = v[2:0]; #1;
      chk("R9", y[0], 8'h17 >> v);
      chk("R9", y[1], 8'hE1 >> v);
    end
    sweep("R2");
    sweep("R5");
  endtask

  task automatic t_pol();
    wr(2'd2, 1, 6'd1);
    wr(2'd2, 0, 6'd0);
    sweep("R8");
    do_commit();
    sweep("R7");
  endtask

  task automatic t_empty_term();
    wr(2'd0, 0, 6'b00_00_00);
    wr(2'd1, 0, 6'b00_0001);
    wr(2'd2, 0, 6'd0);
    do_commit();
    for (int v = 0; v < 8; v++) begin
      x = v[2:0]; #1;
      chk("R4", y[0], 1'b1);
    end
    sweep("R4");
  endtask

  task automatic t_zero();
    wr(2'd0, 0, 6'b01_11_00);
    do_commit();
    for (int v = 0; v < 8; v++) begin
      x = v[2:0]; #1;
      chk("R3", y[0], 1'b0);
    end
  endtask

  task automatic t_empty_col();
    wr(2'd1, 1, 6'd0);
    wr(2'd2, 1, 6'd1);
    do_commit();
    for (int v = 0; v < 8; v++) begin
      x = v[2:0]; #1;
      chk("R6", y[1], 1'b1);
    end
  endtask

  task automatic t_share();
    wr(2'd0, 1, 6'b10_00_01); // A'C
    wr(2'd0, 2, 6'b00_10_00); // B'
    wr(2'd1, 0, 6'b00_0010);
    wr(2'd1, 1, 6'b00_0110);
    wr(2'd2, 1, 6'd0);
    do_commit();
    sweep("R5");
    sweep("R2");
  endtask

  initial begin
    for (int t = 0; t < P; t++) begin sh_and[t] = '0; ac_and[t] = '0; end
    for (int o = 0; o < M; o++) begin
      sh_or[o] = '0; ac_or[o] = '0; sh_pol[o] = 1'b0; ac_pol[o] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pair();
    t_pol();
    t_empty_term();
    t_zero();
    t_empty_col();
    t_share();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule